// File: doc/BRIEF.md
# Host-Driven MDIO Management Slave

This block decodes management frames that a host builds one bit at a time. The host has no real MDC or MDIO pins. It writes a small control word that sets the clock level, and it may also set the data level. The block keeps that line state, finds every clock transition, and walks a fixed frame sequence: preamble, start, a two-bit opcode, a five-bit PHY address, a five-bit register number, a two-bit turnaround, and sixteen data bits. When the data bits are done, it goes back to waiting for preamble.

A read to the configured PHY address fetches one word from an external PHY register file and sends it back on the line, most significant bit first. A read to any other address sends all-ones. Any other opcode is taken as a write. The sixteen captured bits go to the register file as one write strobe, but only when the address matches. The host reads the resolved line level back through a status bit.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While reset is asserted and in the cycles just after it, `mdio_oe`, `stat_mdio`, `reg_rd_en` and `reg_wr_en` are all 0.
- R2: A host write takes bit 2 of the control word as the clock level. Bit 0 becomes the host's data level only when bit 1 is set. A write with bit 1 clear leaves the data level unchanged. `stat_mdio` shows the driven bit while `mdio_oe` is high, and the host's data level otherwise.
- R3: Every clock transition, rising or falling, counts. Preamble ends only at a rising transition where at least 64 transitions have been counted and the data level is 0. A frame sent after a shorter preamble is not decoded.
- R4: After preamble, the fields are taken in this fixed order, each bit on a rising transition and most significant bit first: start bit 1 (one clock), opcode (2 bits), PHY address (5 bits), register number (5 bits), turnaround (2 clocks), data (16 bits). The phase lengths are twice these bit counts in transitions.
- R5: Opcode 2'b10 is a read. If the PHY address equals `phy_addr_cfg`, `reg_rd_en` pulses for one cycle with the register number on `reg_addr`. `reg_rdata` is taken one cycle later. Each data bit is presented on a falling transition, most significant bit first, starting with the falling transition that follows the turnaround.
- R6: A read to a non-matching PHY address produces no `reg_rd_en` and returns 16'hFFFF.
- R7: Every other opcode (2'b00, 2'b01, 2'b11) is a write. Data bits are captured on rising transitions. After the sixteenth bit, `reg_wr_en` pulses for exactly one cycle, with the register number on `reg_addr` and the word on `reg_wdata`.
- R8: A write to a non-matching PHY address produces no `reg_wr_en`, and the target register keeps its value.
- R9: `mdio_oe` is high only during the data phase of a read. It drops after the final rising transition, and the next frame is decoded normally.
- R10: `reg_rd_en` and `reg_wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr_cfg | input | 5 | PHY address this slave answers to (normally 1) |
| ctl_wr | input | 1 | Host control-word write strobe |
| ctl_wdata | input | 3 | Control word: bit 0 data level, bit 1 data load enable, bit 2 clock level |
| stat_mdio | output | 1 | Resolved MDIO line level for host status reads |
| mdio_out | output | 1 | Bit driven by the slave during read data |
| mdio_oe | output | 1 | Slave drive enable |
| reg_rd_en | output | 1 | Register file read strobe |
| reg_wr_en | output | 1 | Register file write strobe |
| reg_addr | output | 5 | Register number for the access |
| reg_wdata | output | 16 | Write word |
| reg_rdata | input | 16 | Read word, valid the cycle after `reg_rd_en` |

## Verification
Some properties are checked on every cycle. Preamble never ends before its transition count is reached. A rising and a falling transition never occur together. A read strobe appears only for a matching read. The strobes are single-cycle and mutually exclusive. The drive enable is high only around the data phase of a read, and the driven bit is quiet when the enable is low. Other properties can be shown only by the bench's frame scenarios: that fields are taken in the right order and bit order, that read words are serialised correctly, that all-ones comes back for a foreign address, that foreign writes are dropped, and that a short preamble aborts decoding.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
  typedef enum logic [2:0] {
    PH_PRE   = 3'd0,
    PH_START = 3'd1,
    PH_OPC   = 3'd2,
    PH_PHYAD = 3'd3,
    PH_REGAD = 3'd4,
    PH_TA    = 3'd5,
    PH_DATA  = 3'd6
  } phase_t;

  localparam logic [1:0] OPC_READ = 2'b10;
  localparam int CTL_W = 3;
  localparam int CTL_VAL = 0;
  localparam int CTL_LD  = 1;
  localparam int CTL_MDC = 2;
endpackage

// File: rtl/mdc_edge_det.sv
module mdc_edge_det
  import mdio_slv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             host_mdio,
  output logic             mdc_rise,
  output logic             mdc_fall,
  output logic             smp_bit
);
  logic mdc_lvl;
  logic nxt_mdio;

  always_comb begin
    nxt_mdio = ctl_wdata[CTL_LD] ? ctl_wdata[CTL_VAL] : host_mdio;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_mdio <= 1'b0;
      mdc_lvl   <= 1'b0;
      mdc_rise  <= 1'b0;
      mdc_fall  <= 1'b0;
      smp_bit   <= 1'b0;
    end else begin
      mdc_rise <= 1'b0;
      mdc_fall <= 1'b0;
      if (ctl_wr) begin
        host_mdio <= nxt_mdio;
        smp_bit   <= nxt_mdio;
        mdc_lvl   <= ctl_wdata[CTL_MDC];
        mdc_rise  <= ctl_wdata[CTL_MDC] & ~mdc_lvl;
        mdc_fall  <= ~ctl_wdata[CTL_MDC] & mdc_lvl;
      end
    end
  end

  // R2: a transition is either rising or falling, never both
  p_edge_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(mdc_rise && mdc_fall));
  // R2: a rising pulse leaves the clock level high
  p_rise_level_r2: assert property (@(posedge clk) disable iff (rst)
    mdc_rise |-> mdc_lvl);
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_slv_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PHYAD_W   = 5,
  parameter int REGAD_W   = 5,
  parameter int PRE_EDGES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mdc_rise,
  input  logic               mdc_fall,
  input  logic               smp_bit,
  input  logic [PHYAD_W-1:0] cfg_addr,
  output phase_t             phase,
  output logic               is_read,
  output logic               addr_match,
  output logic [REGAD_W-1:0] regad,
  output logic [DATA_W-1:0]  wdat,
  output logic               rd_en,
  output logic               wr_en,
  output logic               load_out,
  output logic               shift_out,
  output logic               frame_done
);
  localparam int START_E = 2;
  localparam int OPC_E   = 4;
  localparam int PHYAD_E = 2 * PHYAD_W;
  localparam int REGAD_E = 2 * REGAD_W;
  localparam int TA_E    = 4;
  localparam int DATA_E  = 2 * DATA_W;
  localparam int MAXC    = (PRE_EDGES > DATA_E) ? PRE_EDGES : DATA_E;
  localparam int CNT_W   = $clog2(MAXC + 1) + 1;

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cnt_nx;
  logic [1:0]         opc;
  logic [PHYAD_W-1:0] phyad;
  logic               any_edge;

  assign any_edge   = mdc_rise | mdc_fall;
  assign is_read    = (opc == OPC_READ);
  assign addr_match = (phyad == cfg_addr);

  always_comb begin
    if (cnt >= CNT_W'(MAXC)) cnt_nx = cnt;
    else                     cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_PRE;
      cnt        <= '0;
      opc        <= '0;
      phyad      <= '0;
      regad      <= '0;
      wdat       <= '0;
      rd_en      <= 1'b0;
      wr_en      <= 1'b0;
      load_out   <= 1'b0;
      shift_out  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      rd_en      <= 1'b0;
      wr_en      <= 1'b0;
      load_out   <= 1'b0;
      frame_done <= 1'b0;
      shift_out  <= mdc_fall && (phase == PH_DATA) && is_read;
      if (any_edge) cnt <= cnt_nx;
      unique case (phase)
        PH_PRE: begin
          if (mdc_rise && cnt_nx >= CNT_W'(PRE_EDGES) && !smp_bit) begin
            cnt   <= '0;
            phase <= PH_START;
          end
        end
        PH_START: begin
          if (mdc_rise && cnt_nx == CNT_W'(START_E)) begin
            cnt   <= '0;
            opc   <= '0;
            phase <= PH_OPC;
          end
        end
        PH_OPC: begin
          if (mdc_rise) begin
            opc <= {opc[0], smp_bit};
            if (cnt_nx == CNT_W'(OPC_E)) begin
              cnt   <= '0;
              phyad <= '0;
              phase <= PH_PHYAD;
            end
          end
        end
        PH_PHYAD: begin
          if (mdc_rise) begin
            phyad <= {phyad[PHYAD_W-2:0], smp_bit};
            if (cnt_nx == CNT_W'(PHYAD_E)) begin
              cnt   <= '0;
              regad <= '0;
              phase <= PH_REGAD;
            end
          end
        end
        PH_REGAD: begin
          if (mdc_rise) begin
            regad <= {regad[REGAD_W-2:0], smp_bit};
            if (cnt_nx == CNT_W'(REGAD_E)) begin
              cnt   <= '0;
              phase <= PH_TA;
              rd_en <= is_read && addr_match;
            end
          end
        end
        PH_TA: begin
          if (mdc_rise && cnt_nx == CNT_W'(TA_E)) begin
            cnt      <= '0;
            wdat     <= '0;
            load_out <= 1'b1;
            phase    <= PH_DATA;
          end
        end
        PH_DATA: begin
          if (mdc_rise) begin
            if (!is_read) wdat <= {wdat[DATA_W-2:0], smp_bit};
            if (cnt_nx == CNT_W'(DATA_E)) begin
              cnt        <= '0;
              phase      <= PH_PRE;
              frame_done <= 1'b1;
              wr_en      <= !is_read && addr_match;
            end
          end
        end
        default: phase <= PH_PRE;
      endcase
    end
  end

  // R3: preamble exit only after enough transitions were counted
  p_pre_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_START && $past(phase) == PH_PRE) |-> ($past(cnt) >= CNT_W'(PRE_EDGES - 1)));
  // R6: a read strobe needs a read opcode to a matching address
  p_rd_match_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (is_read && addr_match && phase == PH_TA));
  // R7: write strobe is a single cycle, issued on return to preamble
  p_wr_single_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  p_wr_phase_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (phase == PH_PRE && !is_read));
  // R4: phase encoding stays within the defined sequence
  p_phase_legal_r4: assert property (@(posedge clk) disable iff (rst)
    phase <= PH_DATA);
endmodule

// File: rtl/mdio_read_shifter.sv
module mdio_read_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              addr_match,
  input  logic              is_read,
  input  logic              load_out,
  input  logic              shift_out,
  input  logic              frame_done,
  output logic              mdio_out,
  output logic              mdio_oe
);
  logic              rd_pend;
  logic [DATA_W-1:0] hold;
  logic [DATA_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      hold     <= '0;
      sreg     <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      rd_pend <= rd_en;
      if (rd_pend) hold <= reg_rdata;
      if (frame_done) begin
        mdio_oe  <= 1'b0;
        mdio_out <= 1'b0;
      end else if (load_out && is_read) begin
        sreg     <= addr_match ? hold : '1;
        mdio_oe  <= 1'b1;
        mdio_out <= 1'b0;
      end else if (shift_out && mdio_oe) begin
        mdio_out <= sreg[DATA_W-1];
        sreg     <= {sreg[DATA_W-2:0], 1'b0};
      end
    end
  end

  // R5: loading a read word turns the drive on
  p_load_oe_r5: assert property (@(posedge clk) disable iff (rst)
    (load_out && is_read && !frame_done) |=> mdio_oe);
  // R9: the driven bit is quiet whenever the drive is off
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !mdio_oe |-> !mdio_out);
  // R9: the end of a frame always drops the drive
  p_done_release_r9: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PHYAD_W   = 5,
  parameter int REGAD_W   = 5,
  parameter int PRE_EDGES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHYAD_W-1:0] phy_addr_cfg,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  output logic               stat_mdio,
  output logic               mdio_out,
  output logic               mdio_oe,
  output logic               reg_rd_en,
  output logic               reg_wr_en,
  output logic [REGAD_W-1:0] reg_addr,
  output logic [DATA_W-1:0]  reg_wdata,
  input  logic [DATA_W-1:0]  reg_rdata
);
  logic   host_mdio;
  logic   mdc_rise;
  logic   mdc_fall;
  logic   smp_bit;
  phase_t phase;
  logic   is_read;
  logic   addr_match;
  logic   load_out;
  logic   shift_out;
  logic   frame_done;

  mdc_edge_det u_edge (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .host_mdio (host_mdio),
    .mdc_rise  (mdc_rise),
    .mdc_fall  (mdc_fall),
    .smp_bit   (smp_bit)
  );

  mdio_frame_fsm #(
    .DATA_W    (DATA_W),
    .PHYAD_W   (PHYAD_W),
    .REGAD_W   (REGAD_W),
    .PRE_EDGES (PRE_EDGES)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mdc_rise   (mdc_rise),
    .mdc_fall   (mdc_fall),
    .smp_bit    (smp_bit),
    .cfg_addr   (phy_addr_cfg),
    .phase      (phase),
    .is_read    (is_read),
    .addr_match (addr_match),
    .regad      (reg_addr),
    .wdat       (reg_wdata),
    .rd_en      (reg_rd_en),
    .wr_en      (reg_wr_en),
    .load_out   (load_out),
    .shift_out  (shift_out),
    .frame_done (frame_done)
  );

  mdio_read_shifter #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (reg_rd_en),
    .reg_rdata  (reg_rdata),
    .addr_match (addr_match),
    .is_read    (is_read),
    .load_out   (load_out),
    .shift_out  (shift_out),
    .frame_done (frame_done),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe)
  );

  assign stat_mdio = mdio_oe ? mdio_out : host_mdio;

  // R10: read and write strobes are exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd_en && reg_wr_en));
  // R9: drive only in or right at the end of a read data phase
  p_oe_read_data_r9: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> (is_read && (phase == PH_DATA || $past(phase) == PH_DATA)));
  // R5: a read strobe is a single cycle
  p_rd_single_r5: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |=> !reg_rd_en);
endmodule

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  phy_addr_cfg = 5'd1;
  logic        ctl_wr = 1'b0;
  logic [2:0]  ctl_wdata = 3'b000;
  logic        stat_mdio, mdio_out, mdio_oe, reg_rd_en, reg_wr_en;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;

  int checks = 0;
  int fails = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int oe_seen = 0;
  logic [4:0]  last_wa;
  logic [15:0] last_wd;
  logic [15:0] mem [32];

  always #2 clk = ~clk;

  mdio_mgmt_slave i_mdio_mgmt_slave (
    .clk(clk), .rst(rst), .phy_addr_cfg(phy_addr_cfg), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .stat_mdio(stat_mdio), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // PHY register file model: synchronous read one cycle after the strobe
  initial for (int i = 0; i < 32; i++) mem[i] = 16'h8000 | 16'(i);
  always @(posedge clk) begin
    if (reg_rd_en) begin reg_rdata <= mem[reg_addr]; rd_cnt <= rd_cnt + 1; end
    if (reg_wr_en) begin
      mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1;
      last_wa <= reg_addr; last_wd <= reg_wdata;
    end
    if (mdio_oe) oe_seen <= oe_seen + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic mdc, input logic ld, input logic val);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = {mdc, ld, val};
    @(negedge clk);
    ctl_wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    host_wr(1'b0, 1'b1, b);
    host_wr(1'b1, 1'b1, b);
    host_wr(1'b0, 1'b1, b);
  endtask

  task automatic send_head(input int npre, input logic [1:0] op,
                           input logic [4:0] pa, input logic [4:0] ra);
    for (int i = 0; i < npre; i++) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(pa[i]);
    for (int i = 4; i >= 0; i--) send_bit(ra[i]);
  endtask

  task automatic do_write(input logic [1:0] op, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] d);
    send_head(32, op, pa, ra);
    send_bit(1'b1); send_bit(1'b0);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic do_read(input logic [4:0] pa, input logic [4:0] ra,
                         output logic [15:0] q, output logic oe_ok);
    send_head(32, 2'b10, pa, ra);
    oe_ok = 1'b1;
    host_wr(1'b1, 1'b0, 1'b0); host_wr(1'b0, 1'b0, 1'b0);
    host_wr(1'b1, 1'b0, 1'b0);
    for (int i = 15; i >= 0; i--) begin
      host_wr(1'b0, 1'b0, 1'b0);
      q[i] = stat_mdio;
      if (mdio_oe !== 1'b1) oe_ok = 1'b0;
      host_wr(1'b1, 1'b0, 1'b0);
    end
    host_wr(1'b0, 1'b0, 1'b0);
  endtask

  // Vector table: opcode, PHY address, register, write data / expected read,
  // expected write-strobe and read-strobe increments
  localparam int NV = 8;
  localparam logic [1:0]  V_OP [NV] = '{2'b01, 2'b10, 2'b01, 2'b10, 2'b10, 2'b11, 2'b10, 2'b10};
  localparam logic [4:0]  V_PA [NV] = '{5'd1, 5'd1, 5'd2, 5'd1, 5'd6, 5'd1, 5'd1, 5'd1};
  localparam logic [4:0]  V_RA [NV] = '{5'd3, 5'd3, 5'd3, 5'd3, 5'd3, 5'd9, 5'd9, 5'd0};
  localparam logic [15:0] V_D  [NV] = '{16'hA5C3, 16'hA5C3, 16'h0F0F, 16'hA5C3,
                                        16'hFFFF, 16'h1234, 16'h1234, 16'h8000};
  localparam int          V_WR [NV] = '{1, 0, 0, 0, 0, 1, 0, 0};
  localparam int          V_RD [NV] = '{0, 1, 0, 1, 0, 0, 1, 1};

  initial begin
    automatic logic [15:0] q;
    automatic logic oe_ok;
    automatic int w0, r0, oe0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 oe in reset", mdio_oe, 0);
    chk("R1 strobes in reset", {reg_rd_en, reg_wr_en}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 stat after reset", stat_mdio, 0);
    chk("R1 oe after reset", mdio_oe, 0);

    // R2: load enable gates the host data level
    host_wr(1'b0, 1'b1, 1'b1);
    chk("R2 load sets level", stat_mdio, 1);
    host_wr(1'b0, 1'b0, 1'b0);
    chk("R2 no-load keeps level", stat_mdio, 1);
    host_wr(1'b0, 1'b1, 1'b0);
    chk("R2 load clears level", stat_mdio, 0);

    for (int v = 0; v < NV; v++) begin
      w0 = wr_cnt; r0 = rd_cnt;
      if (V_OP[v] == 2'b10) begin
        do_read(V_PA[v], V_RA[v], q, oe_ok);
        // R5 R6: read word MSB first, all-ones for a foreign address
        chk($sformatf("R5 R6 read data vec %0d", v), q, V_D[v]);
        chk($sformatf("R9 oe during read data vec %0d", v), oe_ok, 1);
        chk($sformatf("R9 oe released vec %0d", v), mdio_oe, 0);
        chk($sformatf("R6 read strobe count vec %0d", v), rd_cnt - r0, V_RD[v]);
      end else begin
        do_write(V_OP[v], V_PA[v], V_RA[v], V_D[v]);
        // R7 R8: one strobe for a matching write, none otherwise
        chk($sformatf("R7 R8 write strobe count vec %0d", v), wr_cnt - w0, V_WR[v]);
        if (V_WR[v] == 1) begin
          chk($sformatf("R7 write addr vec %0d", v), last_wa, V_RA[v]);
          chk($sformatf("R7 write data vec %0d", v), last_wd, V_D[v]);
        end
        chk($sformatf("R10 no read strobe on write vec %0d", v), rd_cnt - r0, 0);
      end
    end

    // R3: short preamble, frame must not be decoded
    r0 = rd_cnt; oe0 = oe_seen;
    send_head(10, 2'b10, 5'd1, 5'd3);
    host_wr(1'b1, 1'b0, 1'b0); host_wr(1'b0, 1'b0, 1'b0);
    chk("R3 short preamble no read", rd_cnt - r0, 0);
    chk("R3 short preamble no drive", oe_seen - oe0, 0);

    // R4 R9: full frame afterwards decodes, fields in order
    do_read(5'd1, 5'd9, q, oe_ok);
    chk("R4 R9 frame after aborted one", q, 16'h1234);

    // R5: another configured address
    phy_addr_cfg = 5'd5;
    do_read(5'd5, 5'd17, q, oe_ok);
    chk("R5 read with address 5", q, 16'h8011);
    do_read(5'd1, 5'd17, q, oe_ok);
    chk("R6 old address now foreign", q, 16'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule